// File: doc/BRIEF.md
# MII Transmit Framer

This block turns a host byte stream into the 4-bit transmit side of a media independent interface. The host presents the first byte of a frame with a start strobe and holds each byte until the framer takes it. The framer sends the preamble and start delimiter, then the data low nibble first. It zero-fills short frames and appends the frame check sequence. Pad, check-sequence and oversize settings come either from static configuration pins or, when the per-packet override is set, from per-packet inputs. These are captured when a frame starts.

Each transmit attempt ends with a one-cycle status strobe. A 26-bit summary vector and exactly one of three outcome pulses (done, retry, abort) come with it. A separate statistics block can count from this vector, so the framer keeps no counters of its own. In half duplex, a collision replaces the rest of the attempt with a jam pattern. An early collision asks the host to retry the frame. A late collision or too many collisions abandons the frame. A slow-rate mode paces nibbles at one clock in four, as for a 10 Mb/s link clocked at four times the nibble rate.

Top module: `mii_tx_framer`

## Requirements
- R1: After a start strobe is accepted, the first 16 nibbles with transmit enable high are fifteen of value 0x5 followed by one of value 0xD.
- R2: Each data byte goes out as two nibbles, bits 3:0 first. `tx_take` pulses for one cycle each time a byte is consumed, and the first such pulse marks that data transmission has begun.
- R3: With padding in effect, a frame of fewer than 60 data bytes is followed by zero bytes until 60 bytes have been sent. Frames of 60 or more bytes are not padded.
- R4: With the check sequence in effect, the frame is followed by 8 nibbles holding the complement of a CRC-32 (reflected polynomial 0xEDB88320, preset all ones) over data and pad, least significant nibble first. With it off, nothing is appended.
- R5: With `pkt_ovr` at 1 the pad, check-sequence and oversize settings come from `pkt_pad`, `pkt_crc` and `pkt_huge`. With `pkt_ovr` at 0 they come from `cfg_pad`, `cfg_crc` and `cfg_huge`.
- R6: An attempt ends with `stat_vld` high for one cycle, transmit enable low, and exactly one of `tx_done`, `tx_retry`, `tx_abort`. The vector fields are: bit 25 success; 24 late-collision abort; 23 and 19 always 0 (no deferral is performed); 22 excessive-collision abort; 21 under-run abort; 20 oversize abort; 18 broadcast; 17 multicast; 16 check error; 15:12 collisions suffered by this frame in earlier attempts; 11 late collision; 10:0 bytes sent after the delimiter (data, pad and check sequence).
- R7: Bit 18 is set when the first six data bytes are all 0xFF. Bit 17 is set when bit 0 of the first data byte is 1 and the frame is not broadcast.
- R8: On success with the check sequence off, bit 16 is set when the CRC register over all sent bytes does not end at the residue 0xDEBB20E3. In that mode the host supplies its own check sequence.
- R9: If `tx_underrun` is high when the next byte is due, one nibble with `mii_txer` high is sent, the attempt aborts and bit 21 is set.
- R10: With oversize frames not allowed, an attempt to take a 1519th data byte sends one error nibble and aborts with bit 20 set. With them allowed, the frame completes.
- R11: A collision before 64 bytes have started after the delimiter replaces the rest of the attempt with eight 0x5 jam nibbles and ends with `tx_retry`. The collision count field rises by one on each retried attempt of the same frame.
- R12: A collision once 64 or more bytes have started after the delimiter sends the jam and aborts with bits 24 and 11 set.
- R13: A collision on the 16th attempt of a frame aborts with bit 22 set and a collision count of 15. The count returns to 0 for the next frame.
- R14: With `slow_mode` at 0, `nib_ce` is always high. With it at 1, `nib_ce` is high one cycle in four. `mii_txd` changes only on edges where `nib_ce` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_mode | input | 1 | 1: one nibble per four clocks |
| cfg_pad | input | 1 | Configured pad enable |
| cfg_crc | input | 1 | Configured check-sequence enable |
| cfg_huge | input | 1 | Configured oversize-frame allowance |
| pkt_ovr | input | 1 | Use per-packet settings |
| pkt_pad | input | 1 | Per-packet pad enable |
| pkt_crc | input | 1 | Per-packet check-sequence enable |
| pkt_huge | input | 1 | Per-packet oversize allowance |
| tx_byte | input | 8 | Host data byte |
| tx_sof | input | 1 | First byte of a frame is present |
| tx_eof | input | 1 | Present byte is the last of the frame |
| tx_underrun | input | 1 | Host has no byte ready |
| col_async | input | 1 | Collision from the PHY, asynchronous |
| nib_ce | output | 1 | Nibble clock enable |
| tx_take | output | 1 | Byte consumed (use-data) |
| tx_done | output | 1 | Attempt completed successfully |
| tx_retry | output | 1 | Attempt ended by an early collision |
| tx_abort | output | 1 | Frame abandoned |
| mii_txd | output | 4 | Transmit nibble |
| mii_txen | output | 1 | Transmit enable |
| mii_txer | output | 1 | Transmit error |
| stat_vec | output | 26 | End-of-attempt status vector |
| stat_vld | output | 1 | Status vector valid, one cycle |

## Verification
Frames are sent with lengths below, at and above the pad minimum, and under each combination of the pad and check-sequence settings, from both the configuration pins and the override. This separates padding from check-sequence insertion and shows which source was selected. Destination patterns for unicast, multicast and broadcast test the address flags. Frames with a correct and a wrong host-supplied check sequence test the residue check. Collisions in the preamble and deep in the data test retry against late abort, and a run of sixteen collided attempts tests the attempt limit. Under-run, an oversize frame with and without the allowance, and slow-rate pacing test the remaining end conditions and the nibble timing.

// File: rtl/mii_tx_framer.sv
module mii_tx_framer #(
  parameter int MIN_DATA      = 60,
  parameter int MAX_DATA      = 1518,
  parameter int LATE_BYTES    = 64,
  parameter int ATTEMPT_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_mode,
  input  logic        cfg_pad,
  input  logic        cfg_crc,
  input  logic        cfg_huge,
  input  logic        pkt_ovr,
  input  logic        pkt_pad,
  input  logic        pkt_crc,
  input  logic        pkt_huge,
  input  logic [7:0]  tx_byte,
  input  logic        tx_sof,
  input  logic        tx_eof,
  input  logic        tx_underrun,
  input  logic        col_async,
  output logic        nib_ce,
  output logic        tx_take,
  output logic        tx_done,
  output logic        tx_retry,
  output logic        tx_abort,
  output logic [3:0]  mii_txd,
  output logic        mii_txen,
  output logic        mii_txer,
  output logic [25:0] stat_vec,
  output logic        stat_vld
);

  localparam logic [31:0] POLY     = 32'hEDB88320;
  localparam logic [31:0] RESIDUE  = 32'hDEBB20E3;
  localparam logic [3:0]  PRE_NIB  = 4'h5;
  localparam logic [3:0]  SFD_NIB  = 4'hD;
  localparam logic [3:0]  JAM_NIB  = 4'h5;
  localparam logic [10:0] CNT_MAX  = '1;
  localparam logic [10:0] MIN_D    = 11'(MIN_DATA);
  localparam logic [10:0] MAX_D    = 11'(MAX_DATA);
  localparam logic [10:0] LATE_B   = 11'(LATE_BYTES);
  localparam logic [3:0]  LAST_TRY = 4'(ATTEMPT_LIMIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DATA, S_PAD, S_FCS, S_JAM, S_FIN} st_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  function automatic logic [10:0] sat_inc(input logic [10:0] v);
    return (v == CNT_MAX) ? v : v + 11'd1;
  endfunction

  st_t         state;
  logic [3:0]  idx;
  logic [1:0]  div;
  logic        col_m, col_s;
  logic [7:0]  cur;
  logic        last;
  logic [10:0] dcnt, bcnt;
  logic [31:0] crc;
  logic        e_pad, e_crc, e_huge;
  logic [3:0]  ncol;
  logic        bc_run, mc;
  logic        o_ok, o_retry, o_late, o_exc, o_und, o_jum;

  assign nib_ce = !slow_mode || (div == 2'd3);

  wire        on_air  = (state == S_PRE) || (state == S_DATA) || (state == S_PAD) || (state == S_FCS);
  wire        hit     = col_s && on_air;
  wire        late    = bcnt >= LATE_B;
  wire [31:0] fcs     = ~crc;
  wire        bc_f    = bc_run && (dcnt >= 11'd6);
  wire        crc_bad = o_ok && !e_crc && (crc != RESIDUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div   <= '0;
      col_m <= 1'b0;
      col_s <= 1'b0;
    end else begin
      div   <= div + 2'd1;
      col_m <= col_async;
      col_s <= col_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      cur      <= '0;
      last     <= 1'b0;
      dcnt     <= '0;
      bcnt     <= '0;
      crc      <= '1;
      e_pad    <= 1'b0;
      e_crc    <= 1'b0;
      e_huge   <= 1'b0;
      ncol     <= '0;
      bc_run   <= 1'b0;
      mc       <= 1'b0;
      o_ok     <= 1'b0;
      o_retry  <= 1'b0;
      o_late   <= 1'b0;
      o_exc    <= 1'b0;
      o_und    <= 1'b0;
      o_jum    <= 1'b0;
      mii_txd  <= '0;
      mii_txen <= 1'b0;
      mii_txer <= 1'b0;
      tx_take  <= 1'b0;
      tx_done  <= 1'b0;
      tx_retry <= 1'b0;
      tx_abort <= 1'b0;
      stat_vld <= 1'b0;
      stat_vec <= '0;
    end else begin
      tx_take  <= 1'b0;
      tx_done  <= 1'b0;
      tx_retry <= 1'b0;
      tx_abort <= 1'b0;
      stat_vld <= 1'b0;
      if (nib_ce) begin
        if (hit) begin
          mii_txd  <= JAM_NIB;
          mii_txen <= 1'b1;
          mii_txer <= 1'b0;
          state    <= S_JAM;
          idx      <= 4'd1;
          o_late   <= late;
          o_exc    <= !late && (ncol == LAST_TRY);
          o_retry  <= !late && (ncol != LAST_TRY);
        end else begin
          case (state)
            S_IDLE: begin
              mii_txen <= 1'b0;
              mii_txer <= 1'b0;
              if (tx_sof) begin
                state   <= S_PRE;
                idx     <= '0;
                e_pad   <= pkt_ovr ? pkt_pad  : cfg_pad;
                e_crc   <= pkt_ovr ? pkt_crc  : cfg_crc;
                e_huge  <= pkt_ovr ? pkt_huge : cfg_huge;
                dcnt    <= '0;
                bcnt    <= '0;
                crc     <= '1;
                last    <= 1'b0;
                bc_run  <= 1'b1;
                mc      <= 1'b0;
                o_ok    <= 1'b0;
                o_retry <= 1'b0;
                o_late  <= 1'b0;
                o_exc   <= 1'b0;
                o_und   <= 1'b0;
                o_jum   <= 1'b0;
              end
            end
            S_PRE: begin
              mii_txen <= 1'b1;
              mii_txd  <= (idx == 4'd15) ? SFD_NIB : PRE_NIB;
              idx      <= idx + 4'd1;
              if (idx == 4'd15) state <= S_DATA;
            end
            S_DATA: begin
              if (!idx[0]) begin
                if (tx_underrun || (!e_huge && dcnt == MAX_D)) begin
                  mii_txd  <= '0;
                  mii_txer <= 1'b1;
                  o_und    <= tx_underrun;
                  o_jum    <= !tx_underrun;
                  state    <= S_FIN;
                end else begin
                  cur     <= tx_byte;
                  mii_txd <= tx_byte[3:0];
                  tx_take <= 1'b1;
                  crc     <= crc_step(crc, tx_byte);
                  dcnt    <= sat_inc(dcnt);
                  bcnt    <= sat_inc(bcnt);
                  last    <= tx_eof;
                  if (dcnt == 11'd0) mc <= tx_byte[0];
                  if (dcnt < 11'd6)  bc_run <= bc_run && (tx_byte == 8'hFF);
                  idx     <= 4'd1;
                end
              end else begin
                mii_txd <= cur[7:4];
                idx     <= '0;
                if (last) begin
                  if (e_pad && dcnt < MIN_D) state <= S_PAD;
                  else if (e_crc)            state <= S_FCS;
                  else begin
                    state <= S_FIN;
                    o_ok  <= 1'b1;
                  end
                end
              end
            end
            S_PAD: begin
              mii_txd <= '0;
              if (!idx[0]) begin
                crc  <= crc_step(crc, 8'h00);
                dcnt <= sat_inc(dcnt);
                bcnt <= sat_inc(bcnt);
                idx  <= 4'd1;
              end else begin
                idx <= '0;
                if (dcnt >= MIN_D) begin
                  if (e_crc) state <= S_FCS;
                  else begin
                    state <= S_FIN;
                    o_ok  <= 1'b1;
                  end
                end
              end
            end
            S_FCS: begin
              mii_txd <= fcs[{idx[2:0], 2'b00} +: 4];
              if (!idx[0]) bcnt <= sat_inc(bcnt);
              idx <= idx + 4'd1;
              if (idx == 4'd7) begin
                state <= S_FIN;
                o_ok  <= 1'b1;
              end
            end
            S_JAM: begin
              mii_txd <= JAM_NIB;
              idx     <= idx + 4'd1;
              if (idx == 4'd7) state <= S_FIN;
            end
            S_FIN: begin
              mii_txd  <= '0;
              mii_txen <= 1'b0;
              mii_txer <= 1'b0;
              stat_vld <= 1'b1;
              tx_done  <= o_ok;
              tx_retry <= o_retry;
              tx_abort <= o_late || o_exc || o_und || o_jum;
              stat_vec <= {o_ok, o_late, 1'b0, o_exc, o_und, o_jum, 1'b0,
                           bc_f, mc && !bc_f, crc_bad, ncol, o_late, bcnt};
              ncol     <= o_retry ? ncol + 4'd1 : 4'd0;
              state    <= S_IDLE;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/mii_tx_framer_chk.sv
module mii_tx_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        slow_mode,
  input logic        nib_ce,
  input logic        tx_take,
  input logic        tx_done,
  input logic        tx_retry,
  input logic        tx_abort,
  input logic [3:0]  mii_txd,
  input logic        mii_txen,
  input logic        mii_txer,
  input logic [25:0] stat_vec,
  input logic        stat_vld
);

  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |-> $countones({tx_done, tx_retry, tx_abort}) == 1);

  a_r6_outcome_has_vld: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || tx_retry || tx_abort) |-> stat_vld);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |=> !stat_vld);

  a_r6_quiet_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |-> !mii_txen);

  a_r6_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (stat_vec[25] && stat_vec[24:20] == 5'd0));

  a_r11_retry_clean: assert property (@(posedge clk) disable iff (!rst_n)
    tx_retry |-> (stat_vec[25:20] == 6'd0));

  a_r9_abort_reason: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (!stat_vec[25] && stat_vec[24:20] != 5'd0));

  a_r6_no_deferral: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |-> (!stat_vec[23] && !stat_vec[19]));

  a_r9_err_on_air: assert property (@(posedge clk) disable iff (!rst_n)
    mii_txer |-> mii_txen);

  a_r2_take_on_air: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> mii_txen);

  a_r14_fast_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_mode |-> nib_ce);

  a_r14_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
    slow_mode && nib_ce ##1 slow_mode |-> !nib_ce);

  a_r14_nibble_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_ce |=> $stable(mii_txd));

endmodule

bind mii_tx_framer mii_tx_framer_chk u_chk (.*);

// File: tb/mii_tx_framer_tb.sv
`timescale 1ns/1ps
module mii_tx_framer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_mode = 1'b0;
  logic        cfg_pad = 1'b1, cfg_crc = 1'b1, cfg_huge = 1'b0;
  logic        pkt_ovr = 1'b0, pkt_pad = 1'b0, pkt_crc = 1'b0, pkt_huge = 1'b0;
  logic [7:0]  tx_byte = '0;
  logic        tx_sof = 1'b0, tx_eof = 1'b0, tx_underrun = 1'b0, col_async = 1'b0;
  logic        nib_ce, tx_take, tx_done, tx_retry, tx_abort;
  logic [3:0]  mii_txd;
  logic        mii_txen, mii_txer;
  logic [25:0] stat_vec;
  logic        stat_vld;

  always #2.5 clk = ~clk;

  mii_tx_framer u_dut (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0]  fb [0:2047];
  logic [7:0]  eb [0:2047];
  logic [3:0]  mon [0:8191];
  logic [3:0]  expn [0:8191];
  int nnib = 0, nerr = 0, nexp = 0, ntake = 0;
  logic [25:0] g_vec;
  logic        g_done, g_retry, g_abort;

  typedef struct packed {
    int unsigned len; logic ovr; logic pp; logic pc; logic slow; int unsigned bcnt;
  } row_t;
  localparam row_t ROWS [7] = '{
    '{10, 1'b0, 1'b0, 1'b0, 1'b0, 64},
    '{70, 1'b0, 1'b0, 1'b0, 1'b0, 74},
    '{10, 1'b1, 1'b0, 1'b1, 1'b0, 14},
    '{10, 1'b1, 1'b1, 1'b0, 1'b0, 60},
    '{60, 1'b0, 1'b0, 1'b0, 1'b0, 64},
    '{20, 1'b0, 1'b0, 1'b0, 1'b1, 64},
    '{10, 1'b1, 1'b0, 1'b0, 1'b0, 10}
  };

  always @(negedge clk) begin
    cycles++;
    if (nib_ce && mii_txen) begin
      if (nnib < 8192) mon[nnib] = mii_txd;
      nnib++;
      if (mii_txer) nerr++;
    end
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n, input logic [31:0] seed);
    logic [31:0] c;
    c = seed;
    for (int k = 0; k < n; k++) begin
      c = c ^ {24'd0, eb[k]};
      for (int b = 0; b < 8; b++) c = c[0] ? (c >> 1) ^ 32'hEDB88320 : c >> 1;
    end
    return c;
  endfunction

  function automatic logic [25:0] mk_vec(input bit ok, late, exc, und, jum, bc, mc, ce,
                                         input int nc, input int bytes);
    return {ok, late, 1'b0, exc, und, jum, 1'b0, bc, mc, ce, 4'(nc), late, 11'(bytes)};
  endfunction

  task automatic send(input int len, input int ua, input int col_at);
    int idx;
    int guard;
    idx = 0; guard = 0;
    nnib = 0; nerr = 0; ntake = 0;
    @(negedge clk);
    tx_byte = fb[0]; tx_eof = (len == 1); tx_sof = 1'b1;
    forever begin
      @(negedge clk);
      guard++;
      if (tx_take) begin
        ntake++; idx++; tx_sof = 1'b0;
        if (idx == ua) tx_underrun = 1'b1;
        else if (idx < len) begin tx_byte = fb[idx]; tx_eof = (idx == len - 1); end
        else tx_eof = 1'b0;
      end
      if (col_at > 0 && nnib >= col_at) col_async = 1'b1;
      if (stat_vld) begin
        g_vec = stat_vec; g_done = tx_done; g_retry = tx_retry; g_abort = tx_abort;
        tx_sof = 1'b0; tx_eof = 1'b0; tx_underrun = 1'b0; col_async = 1'b0;
        break;
      end
      if (guard > 30000) begin
        g_vec = '0; g_done = 0; g_retry = 0; g_abort = 0;
        tx_sof = 1'b0; col_async = 1'b0; tx_underrun = 1'b0;
        chk(0, "attempt never ended", guard, 0);
        break;
      end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic build_exp(input int len, input bit pad, input bit crc, output int nb, output bit ce);
    logic [31:0] c;
    nb = len;
    for (int k = 0; k < len; k++) eb[k] = fb[k];
    if (pad) while (nb < 60) begin eb[nb] = 8'h00; nb++; end
    nexp = 0;
    for (int k = 0; k < 15; k++) begin expn[nexp] = 4'h5; nexp++; end
    expn[nexp] = 4'hD; nexp++;
    for (int k = 0; k < nb; k++) begin
      expn[nexp] = eb[k][3:0]; expn[nexp+1] = eb[k][7:4]; nexp += 2;
    end
    c = ~ref_crc(nb, 32'hFFFFFFFF);
    ce = !crc && (ref_crc(nb, 32'hFFFFFFFF) != 32'hDEBB20E3);
    if (crc) begin
      for (int k = 0; k < 8; k++) begin expn[nexp] = c[4*k +: 4]; nexp++; end
      nb += 4;
    end
  endtask

  task automatic cmp_stream(input string tag);
    int bad_pre, bad_body;
    bad_pre = -1; bad_body = -1;
    for (int k = 0; k < nexp && k < nnib; k++)
      if (mon[k] !== expn[k]) begin
        if (k < 16) begin if (bad_pre < 0) bad_pre = k; end
        else if (bad_body < 0) bad_body = k;
      end
    chk(bad_pre < 0, {"R1 preamble/delimiter ", tag}, bad_pre < 0 ? 0 : mon[bad_pre], bad_pre < 0 ? 0 : expn[bad_pre]);
    chk(bad_body < 0, {"R2 R3 R4 data/pad/fcs nibbles ", tag}, bad_body < 0 ? 0 : mon[bad_body], bad_body < 0 ? 0 : expn[bad_body]);
    chk(nnib == nexp, {"R3 R4 nibble count ", tag}, nnib, nexp);
  endtask

  initial begin
    int nb;
    bit ce;
    bit ep, ec;
    int hi;
    repeat (5) @(negedge clk);
    chk(mii_txen == 0 && stat_vld == 0, "R6 reset: idle outputs", {mii_txen, stat_vld}, 0);
    chk(nib_ce == 1, "R14 reset: fast enable high", nib_ce, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int r = 0; r < 7; r++) begin
      for (int k = 0; k < 2048; k++) fb[k] = 8'(k * 37 + r * 11 + 2);
      fb[0] = 8'h02;
      pkt_ovr = ROWS[r].ovr; pkt_pad = ROWS[r].pp; pkt_crc = ROWS[r].pc; slow_mode = ROWS[r].slow;
      ep = ROWS[r].ovr ? ROWS[r].pp : cfg_pad;
      ec = ROWS[r].ovr ? ROWS[r].pc : cfg_crc;
      build_exp(int'(ROWS[r].len), ep, ec, nb, ce);
      send(int'(ROWS[r].len), -1, 0);
      cmp_stream($sformatf("row %0d", r));
      chk(g_done && !g_retry && !g_abort, $sformatf("R6 row %0d done pulse", r), {g_done, g_retry, g_abort}, 3'b100);
      chk(g_vec == mk_vec(1, 0, 0, 0, 0, 0, 0, ce, 0, int'(ROWS[r].bcnt)),
          $sformatf("R5 R6 R8 row %0d vector", r), g_vec, mk_vec(1, 0, 0, 0, 0, 0, 0, ce, 0, int'(ROWS[r].bcnt)));
      chk(ntake == int'(ROWS[r].len), $sformatf("R2 row %0d takes", r), ntake, ROWS[r].len);
    end
    pkt_ovr = 0; pkt_pad = 0; pkt_crc = 0;

    // R14 pacing in slow mode
    slow_mode = 1'b1;
    hi = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (nib_ce) hi++; end
    chk(hi == 2, "R14 slow enable count in 8 cycles", hi, 2);
    slow_mode = 1'b0;
    repeat (2) @(negedge clk);

    // R7 broadcast and multicast
    for (int k = 0; k < 16; k++) fb[k] = (k < 6) ? 8'hFF : 8'(k);
    send(16, -1, 0);
    chk(g_vec[18] == 1 && g_vec[17] == 0, "R7 broadcast flags", g_vec[18:17], 2'b10);
    fb[0] = 8'h01; fb[1] = 8'h00;
    send(16, -1, 0);
    chk(g_vec[18] == 0 && g_vec[17] == 1, "R7 multicast flags", g_vec[18:17], 2'b01);

    // R8 host-supplied correct check sequence, no append
    for (int k = 0; k < 20; k++) begin fb[k] = 8'(k * 13 + 4); eb[k] = fb[k]; end
    begin
      logic [31:0] c;
      c = ~ref_crc(20, 32'hFFFFFFFF);
      for (int k = 0; k < 4; k++) fb[20 + k] = c[8*k +: 8];
    end
    pkt_ovr = 1; pkt_pad = 0; pkt_crc = 0;
    send(24, -1, 0);
    chk(g_done && g_vec[16] == 0, "R8 good host check sequence", g_vec[16], 0);
    chk(g_vec[10:0] == 24 && nnib == 16 + 48, "R4 R8 nothing appended", nnib, 64);
    pkt_ovr = 0;

    // R9 under-run
    for (int k = 0; k < 20; k++) fb[k] = 8'(k + 2);
    send(20, 5, 0);
    chk(g_abort && g_vec[21] && !g_vec[25], "R9 under-run abort", g_vec[25:20], 6'b000010);
    chk(ntake == 5 && nerr == 1, "R9 takes and error nibble", {ntake[15:0], nerr[15:0]}, {16'd5, 16'd1});
    chk(g_vec[10:0] == 5, "R9 byte count", g_vec[10:0], 5);

    // R10 oversize
    for (int k = 0; k < 1519; k++) fb[k] = 8'(k * 3 + 2);
    fb[0] = 8'h02;
    send(1519, -1, 0);
    chk(g_abort && g_vec[20] && g_vec[10:0] == 1518, "R10 oversize abort", {g_vec[20], g_vec[10:0]}, {1'b1, 11'd1518});
    chk(ntake == 1518 && nerr == 1, "R10 takes before abort", ntake, 1518);
    pkt_ovr = 1; pkt_pad = 1; pkt_crc = 1; pkt_huge = 1;
    send(1519, -1, 0);
    chk(g_done && g_vec[10:0] == 1523, "R5 R10 oversize allowed", g_vec[10:0], 1523);
    pkt_ovr = 0; pkt_huge = 0;

    // R11 early collisions then success
    for (int k = 0; k < 30; k++) fb[k] = 8'(k + 2);
    for (int a = 0; a < 2; a++) begin
      send(30, -1, 4);
      chk(g_retry && g_vec == mk_vec(0, 0, 0, 0, 0, 0, 0, 0, a, 0),
          $sformatf("R11 retry attempt %0d", a), g_vec, mk_vec(0, 0, 0, 0, 0, 0, 0, 0, a, 0));
      chk(nnib >= 8 && mon[nnib-1] == 4'h5, "R11 jam ends attempt", mon[nnib-1], 5);
    end
    send(30, -1, 0);
    chk(g_done && g_vec[15:12] == 2 && g_vec[10:0] == 64, "R11 success after two retries", g_vec[15:0], {4'd2, 1'b0, 11'd64});

    // R12 late collision
    for (int k = 0; k < 200; k++) fb[k] = 8'h3C;
    fb[0] = 8'h02;
    send(200, -1, 16 + 200);
    chk(g_abort && g_vec[24] && g_vec[11] && !g_vec[22], "R12 late collision flags", g_vec[25:20], 6'b010000);
    chk(g_vec[10:0] >= 64, "R12 byte count past limit", g_vec[10:0], 64);
    begin
      bit jam_ok;
      jam_ok = (nnib > 9) && (mon[nnib-9] != 4'h5);
      for (int k = 1; k <= 8; k++) if (nnib < k || mon[nnib-k] != 4'h5) jam_ok = 0;
      chk(jam_ok, "R11 R12 eight jam nibbles", nnib, 0);
    end

    // R13 sixteen collisions
    for (int k = 0; k < 30; k++) fb[k] = 8'(k + 2);
    for (int a = 0; a < 16; a++) begin
      send(30, -1, 4);
      if (a < 15)
        chk(g_retry && g_vec[15:12] == 4'(a), $sformatf("R13 attempt %0d retried", a), g_vec[15:12], a);
      else
        chk(g_abort && g_vec == mk_vec(0, 0, 1, 0, 0, 0, 0, 0, 15, 0), "R13 excessive collisions",
            g_vec, mk_vec(0, 0, 1, 0, 0, 0, 0, 0, 15, 0));
    end
    send(30, -1, 0);
    chk(g_done && g_vec[15:12] == 0, "R13 count cleared for next frame", g_vec[15:12], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule